// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for a processor pipeline. It holds 64 translations. Each translation is tagged with a 20-bit virtual page number and a 6-bit address-space identifier (ASID). A lookup compares the page number and the current ASID against every entry at the same time. Because the ASID is part of the match, translations from different processes can sit in the buffer together, and a context switch needs no flush. A matching entry returns its physical page number together with its dirty, writable and referenced flags. The 12-bit page offset passes through unchanged.

The three top address bits choose the segment before any lookup happens:

| Top bits | Segment | Translated | Cached |
|---|---|---|---|
| `0xx` | user segment | yes | yes |
| `11x` | kernel mapped segment | yes | yes |
| `100` | kernel direct, cached | no | yes |
| `101` | kernel direct, uncached | no | no |

A direct segment gives a physical address equal to the virtual address with its top three bits cleared. A miss is reported to a software handler, and that handler refills one entry by index through the write port. The block does no table walking of its own.

Each lookup ends in one of five outcome states, held in a result register for one cycle after the request:

- IDLE: there was no request.
- HIT: the address was translated, or it fell in a direct segment.
- MISS: no valid entry matched.
- ADDR_ERR: a user-mode access reached a kernel segment.
- MOD_FAULT: a write matched a read-only entry, or an entry whose dirty bit is clear.

The transitions are as follows. Any state goes to IDLE when `req_valid` is low. Otherwise it goes, in priority order, to ADDR_ERR, then to HIT for a direct segment, then to MISS, then to MOD_FAULT, and finally to HIT for a mapped match.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and every response output is low.
- R2: A request in a translated segment hits when a valid entry has the same page number (address bits 31:12) and the same ASID. One clock later `rsp_hit`, `rsp_mapped` and `rsp_cached` are high, and `rsp_pa` equals the entry's physical page number followed by the request's bits 11:0. All 64 entries take part in the search.
- R3: Two entries with the same page number but different ASIDs resolve separately. A lookup whose ASID matches no entry with that page number gives `rsp_miss`.
- R4: Top bits `100` give `rsp_hit` with `rsp_cached` high. Top bits `101` give `rsp_hit` with `rsp_cached` low. In both cases `rsp_mapped` is low and `rsp_pa` is the virtual address with bits 31:29 cleared. Top bits `11x` are translated like the user segment.
- R5: In user mode (`req_user` high), an address with bit 31 set gives `rsp_addr_err` with `rsp_pa` zero. No lookup takes place, so no reference bit changes.
- R6: A write that matches an entry whose writable bit or dirty bit is clear gives `rsp_mod_fault` and no hit. The entry's flags are still reported. A read of the same entry hits.
- R7: Every match sets the entry's reference bit. `rsp_refd` shows the bit as it was before the lookup.
- R8: A refill writes a whole entry at `wr_idx` and clears its reference bit. A lookup in the same cycle sees the old contents, and the new contents apply from the next cycle. A refill overrides a reference-bit set on the same entry in the same cycle.
- R9: When several valid entries match, the lowest index supplies the result and `rsp_multi_hit` is high.
- R10: A cycle with `req_valid` low gives no hit, miss, address error or modification fault on the following cycle.
- R11: An entry whose valid bit is clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_asid | input | 6 | Current address-space identifier |
| req_user | input | 1 | Request made in user mode |
| wr_en | input | 1 | Refill strobe |
| wr_idx | input | 6 | Entry index to refill |
| wr_vpn | input | 20 | Virtual page number of new entry |
| wr_asid | input | 6 | ASID of new entry |
| wr_ppn | input | 20 | Physical page number of new entry |
| wr_valid | input | 1 | Valid bit of new entry |
| wr_dirty | input | 1 | Dirty bit of new entry |
| wr_writable | input | 1 | Writable bit of new entry |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_addr_err | output | 1 | User access to a kernel segment |
| rsp_mod_fault | output | 1 | Write to a read-only or clean page |
| rsp_multi_hit | output | 1 | More than one entry matched |
| rsp_mapped | output | 1 | Result came from an entry |
| rsp_cached | output | 1 | Access may be cached |
| rsp_pa | output | 32 | Physical address |
| rsp_dirty | output | 1 | Dirty bit of matched entry |
| rsp_writable | output | 1 | Writable bit of matched entry |
| rsp_refd | output | 1 | Reference bit of matched entry before this lookup |

## Verification
The assertions check several properties on every cycle:

- An address error arises only from a user request with bit 31 set.
- An idle cycle produces no outcome.
- Direct-segment addresses keep their offset and clear their segment bits.
- A modification fault always comes from a write.
- The priority encoder picks the lowest matching index.
- A refill lands whole at its index, and a reference bit stays set after a lookup that no refill overrides.

Some behaviours need the bench's scenarios and its reference model, because only a sequence of cycles shows them:

- ASID separation between entries with the same page number.
- A same-cycle refill being invisible to a lookup in that cycle.
- The reference bit showing up on the second lookup.
- The multi-hit choice of entry.
- Hits on the last entry after a full fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 6;
    localparam int PPN_W  = 20;
    localparam int SEG_W  = 3;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PPN_W + OFF_W;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic              writable;
        logic              refd;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        SEG_USER,
        SEG_KDIRECT_C,
        SEG_KDIRECT_U,
        SEG_KMAPPED
    } seg_kind_t;

    typedef enum logic [2:0] {
        RES_IDLE,
        RES_HIT,
        RES_MISS,
        RES_ADDR_ERR,
        RES_MOD_FAULT
    } result_t;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [SEG_W-1:0] seg_bits,
    output logic             translated,
    output logic             kernel_only,
    output logic             cacheable
);
    seg_kind_t kind;

    always_comb begin
        unique casez (seg_bits)
            3'b0??:  kind = SEG_USER;
            3'b100:  kind = SEG_KDIRECT_C;
            3'b101:  kind = SEG_KDIRECT_U;
            default: kind = SEG_KMAPPED;
        endcase
    end

    always_comb begin
        translated  = (kind == SEG_USER) || (kind == SEG_KMAPPED);
        kernel_only = (kind != SEG_USER);
        cacheable   = (kind != SEG_KDIRECT_U);
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic [ASID_W-1:0]  look_asid,
    output logic [ENTRIES-1:0] match_vec,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [PPN_W-1:0]   rd_ppn,
    output logic               rd_dirty,
    output logic               rd_writable,
    output logic               rd_refd,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  tlb_entry_t         wr_entry,
    input  logic               ref_en,
    input  logic [IDX_W-1:0]   ref_idx
);
    tlb_entry_t ents [ENTRIES];

    // A refill written last overrides a reference-bit set on the same entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents[i] <= '0;
            end
        end else begin
            if (ref_en) begin
                ents[ref_idx].refd <= 1'b1;
            end
            if (wr_en) begin
                ents[wr_idx] <= wr_entry;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ents[g].valid
                            && (ents[g].vpn == look_vpn)
                            && (ents[g].asid == look_asid);
    end

    assign rd_ppn      = ents[rd_idx].ppn;
    assign rd_dirty    = ents[rd_idx].dirty;
    assign rd_writable = ents[rd_idx].writable;
    assign rd_refd     = ents[rd_idx].refd;

    // R8
    refill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ents[$past(wr_idx)] == $past(wr_entry)));

    // R7
    ref_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && !(wr_en && (wr_idx == ref_idx))) |=> ents[$past(ref_idx)].refd);
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output logic               multi
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        multi = found && ((match_vec & ~(ENTRIES'(1) << idx)) != '0);
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_user,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_writable,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_addr_err,
    output logic              rsp_mod_fault,
    output logic              rsp_multi_hit,
    output logic              rsp_mapped,
    output logic              rsp_cached,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_dirty,
    output logic              rsp_writable,
    output logic              rsp_refd
);
    logic [VPN_W-1:0]   req_vpn;
    logic [OFF_W-1:0]   req_off;
    logic [VA_W-1:0]    va_stripped;
    logic               translated, kernel_only, cacheable;
    logic [ENTRIES-1:0] match_vec;
    logic               found, multi;
    logic [IDX_W-1:0]   hit_idx;
    logic [PPN_W-1:0]   hit_ppn;
    logic               hit_dirty, hit_writable, hit_refd;
    logic               ref_en;
    tlb_entry_t         wr_ent;

    result_t            nxt_res, res_q;
    logic [PA_W-1:0]    nxt_pa, pa_q;
    logic               nxt_mapped, nxt_cached, nxt_multi;
    logic               mapped_q, cached_q, multi_q;
    logic [2:0]         nxt_flags, flags_q;

    assign req_vpn     = req_vaddr[VA_W-1:OFF_W];
    assign req_off     = req_vaddr[OFF_W-1:0];
    assign va_stripped = {SEG_W'(0), req_vaddr[VA_W-SEG_W-1:0]};

    tlb_seg_decode u_seg (
        .seg_bits    (req_vaddr[VA_W-1 -: SEG_W]),
        .translated  (translated),
        .kernel_only (kernel_only),
        .cacheable   (cacheable)
    );

    always_comb begin
        wr_ent          = '0;
        wr_ent.valid    = wr_valid;
        wr_ent.dirty    = wr_dirty;
        wr_ent.writable = wr_writable;
        wr_ent.refd     = 1'b0;
        wr_ent.asid     = wr_asid;
        wr_ent.vpn      = wr_vpn;
        wr_ent.ppn      = wr_ppn;
    end

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_vpn    (req_vpn),
        .look_asid   (req_asid),
        .match_vec   (match_vec),
        .rd_idx      (hit_idx),
        .rd_ppn      (hit_ppn),
        .rd_dirty    (hit_dirty),
        .rd_writable (hit_writable),
        .rd_refd     (hit_refd),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_entry    (wr_ent),
        .ref_en      (ref_en),
        .ref_idx     (hit_idx)
    );

    tlb_prio #(.ENTRIES(ENTRIES)) u_prio (
        .match_vec (match_vec),
        .found     (found),
        .idx       (hit_idx),
        .multi     (multi)
    );

    // Next-outcome selection.
    always_comb begin
        nxt_res    = RES_IDLE;
        nxt_pa     = '0;
        nxt_mapped = 1'b0;
        nxt_cached = 1'b0;
        nxt_multi  = 1'b0;
        nxt_flags  = 3'b000;
        ref_en     = 1'b0;
        if (req_valid) begin
            if (req_user && kernel_only) begin
                nxt_res = RES_ADDR_ERR;
            end else if (!translated) begin
                nxt_res    = RES_HIT;
                nxt_pa     = PA_W'(va_stripped);
                nxt_cached = cacheable;
            end else if (!found) begin
                nxt_res = RES_MISS;
            end else begin
                ref_en    = 1'b1;
                nxt_multi = multi;
                nxt_flags = {hit_dirty, hit_writable, hit_refd};
                if (req_write && !(hit_writable && hit_dirty)) begin
                    nxt_res = RES_MOD_FAULT;
                end else begin
                    nxt_res    = RES_HIT;
                    nxt_pa     = {hit_ppn, req_off};
                    nxt_mapped = 1'b1;
                    nxt_cached = 1'b1;
                end
            end
        end
    end

    // Result state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q    <= RES_IDLE;
            pa_q     <= '0;
            mapped_q <= 1'b0;
            cached_q <= 1'b0;
            multi_q  <= 1'b0;
            flags_q  <= '0;
        end else begin
            res_q    <= nxt_res;
            pa_q     <= nxt_pa;
            mapped_q <= nxt_mapped;
            cached_q <= nxt_cached;
            multi_q  <= nxt_multi;
            flags_q  <= nxt_flags;
        end
    end

    // Output decode.
    always_comb begin
        rsp_hit       = 1'b0;
        rsp_miss      = 1'b0;
        rsp_addr_err  = 1'b0;
        rsp_mod_fault = 1'b0;
        unique case (res_q)
            RES_HIT:       rsp_hit       = 1'b1;
            RES_MISS:      rsp_miss      = 1'b1;
            RES_ADDR_ERR:  rsp_addr_err  = 1'b1;
            RES_MOD_FAULT: rsp_mod_fault = 1'b1;
            default:       ;
        endcase
        rsp_pa        = pa_q;
        rsp_mapped    = mapped_q;
        rsp_cached    = cached_q;
        rsp_multi_hit = multi_q;
        rsp_dirty     = flags_q[2];
        rsp_writable  = flags_q[1];
        rsp_refd      = flags_q[0];
    end

    logic [ENTRIES-1:0] below_mask;
    assign below_mask = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);

    // R5
    addr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_err |-> $past(req_valid && req_user && req_vaddr[VA_W-1]));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_hit || rsp_miss || rsp_addr_err || rsp_mod_fault));

    // R4
    direct_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_mapped) |->
            (rsp_pa[PA_W-1 -: SEG_W] == '0) && (rsp_pa[OFF_W-1:0] == $past(req_off)));

    // R6
    fault_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_mod_fault |-> ($past(req_write) && !(rsp_dirty && rsp_writable)));

    // R9
    lowest_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (match_vec[hit_idx] && ((match_vec & below_mask) == '0)));
endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_write, req_user;
    logic [31:0] req_vaddr;
    logic [5:0]  req_asid;
    logic        wr_en, wr_valid, wr_dirty, wr_writable;
    logic [5:0]  wr_idx, wr_asid;
    logic [19:0] wr_vpn, wr_ppn;
    logic        rsp_hit, rsp_miss, rsp_addr_err, rsp_mod_fault, rsp_multi_hit;
    logic        rsp_mapped, rsp_cached, rsp_dirty, rsp_writable, rsp_refd;
    logic [31:0] rsp_pa;

    always #10 clk = ~clk;

    asid_tlb #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_asid(req_asid), .req_user(req_user),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_ppn(wr_ppn), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_writable(wr_writable),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_addr_err(rsp_addr_err),
        .rsp_mod_fault(rsp_mod_fault), .rsp_multi_hit(rsp_multi_hit),
        .rsp_mapped(rsp_mapped), .rsp_cached(rsp_cached), .rsp_pa(rsp_pa),
        .rsp_dirty(rsp_dirty), .rsp_writable(rsp_writable), .rsp_refd(rsp_refd)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";
    string exp_req = "R1";

    logic [41:0] act;
    logic [41:0] exp_vec = '0;
    assign act = {rsp_hit, rsp_miss, rsp_addr_err, rsp_mod_fault, rsp_multi_hit,
                  rsp_mapped, rsp_cached, rsp_dirty, rsp_writable, rsp_refd, rsp_pa};

    // Behavioural reference state.
    logic        m_valid [N];
    logic        m_dirty [N];
    logic        m_wr    [N];
    logic        m_ref   [N];
    logic [5:0]  m_asid  [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];

    always @(posedge clk) begin
        logic        e_hit, e_miss, e_aerr, e_mf, e_multi, e_map, e_cac, e_d, e_w, e_r;
        logic [31:0] e_pa;
        int          first, count;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_wr[i] = 1'b0; m_ref[i] = 1'b0;
                m_asid[i] = '0; m_vpn[i] = '0; m_ppn[i] = '0;
            end
            exp_vec = '0;
        end else begin
            {e_hit, e_miss, e_aerr, e_mf, e_multi, e_map, e_cac, e_d, e_w, e_r} = '0;
            e_pa  = '0;
            first = -1;
            count = 0;
            if (req_valid) begin
                if (req_user && req_vaddr[31]) begin
                    e_aerr = 1'b1;
                end else if (req_vaddr[31:29] == 3'b100 || req_vaddr[31:29] == 3'b101) begin
                    e_hit = 1'b1;
                    e_cac = (req_vaddr[31:29] == 3'b100);
                    e_pa  = {3'b000, req_vaddr[28:0]};
                end else begin
                    for (int i = 0; i < N; i++) begin
                        if (m_valid[i] && m_vpn[i] == req_vaddr[31:12] && m_asid[i] == req_asid) begin
                            count++;
                            if (first < 0) first = i;
                        end
                    end
                    if (first < 0) begin
                        e_miss = 1'b1;
                    end else begin
                        e_multi = (count > 1);
                        e_d = m_dirty[first];
                        e_w = m_wr[first];
                        e_r = m_ref[first];
                        if (req_write && !(m_wr[first] && m_dirty[first])) begin
                            e_mf = 1'b1;
                        end else begin
                            e_hit = 1'b1; e_map = 1'b1; e_cac = 1'b1;
                            e_pa  = {m_ppn[first], req_vaddr[11:0]};
                        end
                    end
                end
            end
            if (first >= 0) m_ref[first] = 1'b1;
            if (wr_en) begin
                m_valid[wr_idx] = wr_valid; m_dirty[wr_idx] = wr_dirty;
                m_wr[wr_idx] = wr_writable; m_ref[wr_idx] = 1'b0;
                m_asid[wr_idx] = wr_asid; m_vpn[wr_idx] = wr_vpn; m_ppn[wr_idx] = wr_ppn;
            end
            exp_vec = {e_hit, e_miss, e_aerr, e_mf, e_multi, e_map, e_cac, e_d, e_w, e_r, e_pa};
        end
        exp_req = cur_req;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (act !== exp_vec) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", exp_req, act, exp_vec);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic clear_inputs();
        req_valid = 0; req_write = 0; req_user = 0; req_vaddr = '0; req_asid = '0;
        wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_asid = '0; wr_ppn = '0;
        wr_valid = 0; wr_dirty = 0; wr_writable = 0;
    endtask

    task automatic set_refill(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                              input logic [19:0] ppn, input logic v, input logic d, input logic w);
        wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn;
        wr_valid = v; wr_dirty = d; wr_writable = w;
    endtask

    task automatic set_look(input logic [31:0] va, input logic [5:0] asid,
                            input logic user, input logic wr);
        req_valid = 1; req_vaddr = va; req_asid = asid; req_user = user; req_write = wr;
    endtask

    task automatic refill(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                          input logic [19:0] ppn, input logic v, input logic d, input logic w);
        @(negedge clk);
        clear_inputs();
        set_refill(idx, vpn, asid, ppn, v, d, w);
    endtask

    task automatic look(input logic [31:0] va, input logic [5:0] asid,
                        input logic user, input logic wr);
        @(negedge clk);
        clear_inputs();
        set_look(va, asid, user, wr);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            clear_inputs();
        end
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        checks++;
        if (act !== '0) begin
            errors++;
            $display("FAIL R1 actual=%h expected=%h", act, 42'h0);
        end
        rst_n = 1;
        cur_req = "R1";
        look(32'h0001_2345, 6'd3, 1, 0);
        look(32'h0000_0000, 6'd0, 0, 0);

        cur_req = "R2";
        refill(5,  20'h00012, 6'd3, 20'hABCDE, 1, 1, 1);
        refill(6,  20'h00012, 6'd4, 20'h11111, 1, 1, 0);
        refill(0,  20'hE0010, 6'd1, 20'h0F0F0, 1, 0, 1);
        refill(63, 20'h60001, 6'd2, 20'h77777, 1, 1, 1);
        look(32'h0001_2345, 6'd3, 1, 0);
        look(32'h6000_1FFF, 6'd2, 1, 0);

        cur_req = "R3";
        look(32'h0001_2000, 6'd4, 1, 0);
        look(32'h0001_2000, 6'd5, 1, 0);

        cur_req = "R11";
        refill(10, 20'h00055, 6'd3, 20'h12345, 0, 1, 1);
        look(32'h0005_5000, 6'd3, 1, 0);

        cur_req = "R4";
        look(32'h8000_1234, 6'd0, 0, 0);
        look(32'hA000_5678, 6'd0, 0, 1);
        look(32'hE001_0ABC, 6'd1, 0, 0);

        cur_req = "R5";
        look(32'h8000_0000, 6'd0, 1, 0);
        look(32'hE001_0ABC, 6'd1, 1, 0);
        look(32'hE001_0ABC, 6'd1, 0, 0);

        cur_req = "R6";
        look(32'h0001_2004, 6'd4, 1, 1);
        look(32'h0001_2004, 6'd4, 1, 0);
        look(32'hE001_0000, 6'd1, 0, 1);
        look(32'h0001_2008, 6'd3, 1, 1);

        cur_req = "R7";
        refill(7, 20'h00099, 6'd9, 20'h54321, 1, 1, 1);
        look(32'h0009_9000, 6'd9, 1, 0);
        look(32'h0009_9000, 6'd9, 1, 0);

        cur_req = "R8";
        @(negedge clk);
        clear_inputs();
        set_look(32'h0001_2010, 6'd3, 1, 0);
        set_refill(5, 20'h00012, 6'd3, 20'h22222, 1, 1, 1);
        look(32'h0001_2010, 6'd3, 1, 0);
        look(32'h0001_2010, 6'd3, 1, 0);

        cur_req = "R9";
        refill(40, 20'h00333, 6'd2, 20'h44444, 1, 1, 1);
        refill(20, 20'h00333, 6'd2, 20'h33333, 1, 1, 1);
        look(32'h0033_3abc, 6'd2, 1, 0);
        refill(20, 20'h00333, 6'd2, 20'h33333, 0, 1, 1);
        look(32'h0033_3abc, 6'd2, 1, 0);

        cur_req = "R10";
        idle(3);

        cur_req = "R2";
        for (int i = 0; i < N; i++) refill(i, 20'h00100 + 20'(i), 6'd7, 20'h40000 + 20'(i), 1, 1, 1);
        for (int i = 0; i < N; i++) look({20'h00100 + 20'(i), 12'h5A5}, 6'd7, 1, 0);
        cur_req = "R3";
        look({20'h0013F, 12'h000}, 6'd6, 1, 0);
        cur_req = "R10";
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule